// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR3 interface. It walks a memory device from power-on, or from a reset with stable supplies, to the point where normal commands may be issued. After a start request it holds the device reset pin low and keeps the clock enable low. It then releases reset and waits for the device to settle before raising clock enable. Next it loads the four mode registers in the fixed order the device requires and issues a long ZQ calibration. It raises a done flag only once the DLL lock time and the calibration time have both elapsed.

All wall-clock delays are given in picoseconds and turned into whole clock cycles at elaboration. Each of these conversions rounds up. Command-spaced delays are given directly in clock cycles. The caller supplies the four mode-register op-codes and a flag that picks the long cold-start reset hold or the short warm-reset hold. A start request is taken only while the block is idle or done.

Top module: `ddr3_init_seq`

## Requirements
- R1: While rst_ni is low, and afterwards until a start is accepted, the outputs are ddr_reset_n_o=0, ddr_cke_o=0, ddr_odt_o=0, deselect (cs_n=1, ras_n=1, cas_n=1, we_n=1), bank and address zero, done_o=0.
- R2: The first cycle after start_i is sampled high in idle or done opens the reset hold. ddr_reset_n_o then stays low for ceil(T_RST_COLD_PS/CLK_PERIOD_PS) cycles when cold_i was 1, or ceil(T_RST_WARM_PS/CLK_PERIOD_PS) cycles when cold_i was 0. The hold is never shorter than the clock-enable lead time in R3.
- R3: ddr_cke_o is low throughout the reset hold, and for at least ceil(T_CKE_PRE_PS/CLK_PERIOD_PS) cycles before ddr_reset_n_o rises.
- R4: ddr_cke_o rises exactly ceil(T_CKE_WAIT_PS/CLK_PERIOD_PS) cycles after ddr_reset_n_o rises. Command outputs are deselect with address zero until then.
- R5: The first mode-register-set command appears T_XPR_CK cycles after ddr_cke_o rises.
- R6: Four MRS commands (cs_n, ras_n, cas_n, we_n all 0) are issued. Their bank values are 2, 3, 1, 0 in that order. Each carries mr2_i, mr3_i, mr1_i, mr0_i respectively on the address outputs.
- R7: Consecutive MRS commands are T_MRD_CK cycles apart. ZQCL follows the last MRS after T_MOD_CK cycles, encoded as cs_n=0, ras_n=1, cas_n=1, we_n=0, with address bit 10 set, all other address bits zero and bank zero.
- R8: From the rise of ddr_cke_o until done, every cycle that is not an MRS or ZQCL carries a NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1) with bank and address zero.
- R9: done_o rises max(T_DLLK_CK, T_ZQINIT_CK) cycles after the ZQCL cycle. It stays high, with NOP on the command outputs, until the next accepted start.
- R10: ddr_odt_o is held low for the whole sequence and afterwards.
- R11: start_i and cold_i are ignored while a sequence is running. The output sequence is unchanged by them.
- R12: A start accepted while done_o is high restarts at the reset hold in the next cycle, with the hold length chosen by cold_i in that start cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to run the sequence |
| cold_i | input | 1 | 1 selects the cold-start reset hold, 0 the warm-reset hold |
| mr0_i | input | ADDR_W | Op-code for mode register 0 |
| mr1_i | input | ADDR_W | Op-code for mode register 1 |
| mr2_i | input | ADDR_W | Op-code for mode register 2 |
| mr3_i | input | ADDR_W | Op-code for mode register 3 |
| ddr_reset_n_o | output | 1 | Device reset, active low |
| ddr_cke_o | output | 1 | Device clock enable |
| ddr_odt_o | output | 1 | Device on-die termination control |
| ddr_cs_n_o | output | 1 | Chip select, active low |
| ddr_ras_n_o | output | 1 | Row strobe, active low |
| ddr_cas_n_o | output | 1 | Column strobe, active low |
| ddr_we_n_o | output | 1 | Write enable, active low |
| ddr_ba_o | output | BA_W | Bank address |
| ddr_addr_o | output | ADDR_W | Address / op-code |
| done_o | output | 1 | Device ready for normal commands |

## Verification
Every output is a decode of the phase register. The result of a start sampled at one edge is therefore visible from the next edge on. The bench counts offset k from the first falling edge after that start edge. The hold covers k below H. Clock enable rises at H+W. The MRS commands fall at H+W+XPR plus multiples of T_MRD_CK. ZQCL follows the last of them by T_MOD_CK, and done follows ZQCL by the longer of the DLL and calibration times. The bench compares every output on every falling edge against that offset schedule. A one-cycle slip in any counter therefore shows up as a mismatch in a named phase.

// File: rtl/ddr3_init_pkg.sv
package ddr3_init_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RST_HOLD,
    ST_CKE_WAIT,
    ST_XPR,
    ST_MRS,
    ST_MRD_WAIT,
    ST_MOD_WAIT,
    ST_ZQCL,
    ST_ZQ_WAIT,
    ST_DONE
  } init_state_e;

  typedef enum logic [1:0] {
    CMD_DES,
    CMD_NOP,
    CMD_MRS,
    CMD_ZQCL
  } init_cmd_e;

  // mode register written at each MRS step; order is mandatory
  localparam logic [1:0] MR_SEQ [4] = '{2'd2, 2'd3, 2'd1, 2'd0};

  localparam int unsigned ZQCL_ADDR_BIT = 10;

  function automatic int unsigned cdiv(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // cycles of filler after a one-cycle command so the next lands n cycles later
  function automatic int unsigned gap_len(input int unsigned n);
    return (n > 1) ? n - 1 : 1;
  endfunction

endpackage

// File: rtl/ddr3_init_timer.sv
module ddr3_init_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= load_val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  AST_TMR_STAYS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o && !load_i |=> zero_o); // R2

endmodule

// File: rtl/ddr3_init_mr_sel.sv
module ddr3_init_mr_sel
  import ddr3_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned BA_W   = 3
) (
  input  logic [1:0]        step_i,
  input  logic [ADDR_W-1:0] mr0_i,
  input  logic [ADDR_W-1:0] mr1_i,
  input  logic [ADDR_W-1:0] mr2_i,
  input  logic [ADDR_W-1:0] mr3_i,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] op_o
);

  logic [ADDR_W-1:0] mr_tbl [4];
  logic [1:0]        sel;

  assign mr_tbl[0] = mr0_i;
  assign mr_tbl[1] = mr1_i;
  assign mr_tbl[2] = mr2_i;
  assign mr_tbl[3] = mr3_i;

  assign sel  = MR_SEQ[step_i];
  assign ba_o = BA_W'(sel);
  assign op_o = mr_tbl[sel];

endmodule

// File: rtl/ddr3_init_cmd_enc.sv
module ddr3_init_cmd_enc
  import ddr3_init_pkg::*;
(
  input  init_cmd_e cmd_i,
  output logic      cs_n_o,
  output logic      ras_n_o,
  output logic      cas_n_o,
  output logic      we_n_o
);

  always_comb begin
    unique case (cmd_i)
      CMD_NOP:  {cs_n_o, ras_n_o, cas_n_o, we_n_o} = 4'b0111;
      CMD_MRS:  {cs_n_o, ras_n_o, cas_n_o, we_n_o} = 4'b0000;
      CMD_ZQCL: {cs_n_o, ras_n_o, cas_n_o, we_n_o} = 4'b0110;
      default:  {cs_n_o, ras_n_o, cas_n_o, we_n_o} = 4'b1111;
    endcase
  end

endmodule

// File: rtl/ddr3_init_seq.sv
module ddr3_init_seq
  import ddr3_init_pkg::*;
#(
  parameter int unsigned ADDR_W         = 14,
  parameter int unsigned BA_W           = 3,
  parameter int unsigned CLK_PERIOD_PS  = 1250,
  parameter int unsigned T_RST_COLD_PS  = 200_000_000,
  parameter int unsigned T_RST_WARM_PS  = 100_000,
  parameter int unsigned T_CKE_PRE_PS   = 10_000,
  parameter int unsigned T_CKE_WAIT_PS  = 500_000_000,
  parameter int unsigned T_XPR_CK       = 120,
  parameter int unsigned T_MRD_CK       = 4,
  parameter int unsigned T_MOD_CK       = 12,
  parameter int unsigned T_DLLK_CK      = 512,
  parameter int unsigned T_ZQINIT_CK    = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cold_i,
  input  logic [ADDR_W-1:0] mr0_i,
  input  logic [ADDR_W-1:0] mr1_i,
  input  logic [ADDR_W-1:0] mr2_i,
  input  logic [ADDR_W-1:0] mr3_i,
  output logic              ddr_reset_n_o,
  output logic              ddr_cke_o,
  output logic              ddr_odt_o,
  output logic              ddr_cs_n_o,
  output logic              ddr_ras_n_o,
  output logic              ddr_cas_n_o,
  output logic              ddr_we_n_o,
  output logic [BA_W-1:0]   ddr_ba_o,
  output logic [ADDR_W-1:0] ddr_addr_o,
  output logic              done_o
);

  localparam int unsigned CKE_PRE_CYC = cdiv(T_CKE_PRE_PS, CLK_PERIOD_PS);
  localparam int unsigned HOLD_COLD   = umax(umax(cdiv(T_RST_COLD_PS, CLK_PERIOD_PS), CKE_PRE_CYC), 1);
  localparam int unsigned HOLD_WARM   = umax(umax(cdiv(T_RST_WARM_PS, CLK_PERIOD_PS), CKE_PRE_CYC), 1);
  localparam int unsigned CKE_WAIT    = umax(cdiv(T_CKE_WAIT_PS, CLK_PERIOD_PS), 1);
  localparam int unsigned XPR_LEN     = umax(T_XPR_CK, 1);
  localparam int unsigned MRD_LEN     = gap_len(T_MRD_CK);
  localparam int unsigned MOD_LEN     = gap_len(T_MOD_CK);
  localparam int unsigned ZQ_LEN      = gap_len(umax(T_DLLK_CK, T_ZQINIT_CK));
  localparam int unsigned MAX_LEN     = umax(umax(umax(HOLD_COLD, HOLD_WARM), umax(CKE_WAIT, XPR_LEN)),
                                             umax(umax(MRD_LEN, MOD_LEN), ZQ_LEN));
  localparam int unsigned CNT_W       = $clog2(MAX_LEN + 1);

  localparam logic [CNT_W-1:0] HOLD_COLD_V = CNT_W'(HOLD_COLD - 1);
  localparam logic [CNT_W-1:0] HOLD_WARM_V = CNT_W'(HOLD_WARM - 1);
  localparam logic [CNT_W-1:0] CKE_WAIT_V  = CNT_W'(CKE_WAIT - 1);
  localparam logic [CNT_W-1:0] XPR_V       = CNT_W'(XPR_LEN - 1);
  localparam logic [CNT_W-1:0] MRD_V       = CNT_W'(MRD_LEN - 1);
  localparam logic [CNT_W-1:0] MOD_V       = CNT_W'(MOD_LEN - 1);
  localparam logic [CNT_W-1:0] ZQ_V        = CNT_W'(ZQ_LEN - 1);
  localparam logic [ADDR_W-1:0] ZQ_ADDR    = ADDR_W'(1) << ZQCL_ADDR_BIT;

  init_state_e      state_q, state_d;
  logic [1:0]       step_q, step_d;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_zero;
  init_cmd_e        cmd;
  logic [BA_W-1:0]  mr_ba;
  logic [ADDR_W-1:0] mr_op;
  logic             busy;

  ddr3_init_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  ddr3_init_mr_sel #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_mr_sel (
    .step_i (step_q),
    .mr0_i  (mr0_i),
    .mr1_i  (mr1_i),
    .mr2_i  (mr2_i),
    .mr3_i  (mr3_i),
    .ba_o   (mr_ba),
    .op_o   (mr_op)
  );

  ddr3_init_cmd_enc u_cmd_enc (
    .cmd_i   (cmd),
    .cs_n_o  (ddr_cs_n_o),
    .ras_n_o (ddr_ras_n_o),
    .cas_n_o (ddr_cas_n_o),
    .we_n_o  (ddr_we_n_o)
  );

  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE, ST_DONE: if (start_i) begin
        state_d  = ST_RST_HOLD;
        step_d   = '0;
        tmr_load = 1'b1;
        tmr_val  = cold_i ? HOLD_COLD_V : HOLD_WARM_V;
      end
      ST_RST_HOLD: if (tmr_zero) begin
        state_d  = ST_CKE_WAIT;
        tmr_load = 1'b1;
        tmr_val  = CKE_WAIT_V;
      end
      ST_CKE_WAIT: if (tmr_zero) begin
        state_d  = ST_XPR;
        tmr_load = 1'b1;
        tmr_val  = XPR_V;
      end
      ST_XPR: if (tmr_zero) state_d = ST_MRS;
      ST_MRS: begin
        step_d   = step_q + 2'd1;
        tmr_load = 1'b1;
        if (step_q == 2'd3) begin
          state_d = ST_MOD_WAIT;
          tmr_val = MOD_V;
        end else begin
          state_d = ST_MRD_WAIT;
          tmr_val = MRD_V;
        end
      end
      ST_MRD_WAIT: if (tmr_zero) state_d = ST_MRS;
      ST_MOD_WAIT: if (tmr_zero) state_d = ST_ZQCL;
      ST_ZQCL: begin
        state_d  = ST_ZQ_WAIT;
        tmr_load = 1'b1;
        tmr_val  = ZQ_V;
      end
      ST_ZQ_WAIT: if (tmr_zero) state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_IDLE, ST_RST_HOLD, ST_CKE_WAIT: cmd = CMD_DES;
      ST_MRS:                            cmd = CMD_MRS;
      ST_ZQCL:                           cmd = CMD_ZQCL;
      default:                           cmd = CMD_NOP;
    endcase
  end

  assign ddr_reset_n_o = !(state_q inside {ST_IDLE, ST_RST_HOLD});
  assign ddr_cke_o     = !(state_q inside {ST_IDLE, ST_RST_HOLD, ST_CKE_WAIT});
  assign ddr_odt_o     = 1'b0;
  assign ddr_ba_o      = (state_q == ST_MRS) ? mr_ba : '0;
  assign ddr_addr_o    = (state_q == ST_MRS)  ? mr_op :
                         (state_q == ST_ZQCL) ? ZQ_ADDR : '0;
  assign done_o        = (state_q == ST_DONE);
  assign busy          = !(state_q inside {ST_IDLE, ST_DONE});

  logic is_mrs;
  assign is_mrs = !ddr_cs_n_o && !ddr_ras_n_o && !ddr_cas_n_o && !ddr_we_n_o;

  AST_CKE_LOW_IN_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ddr_reset_n_o |-> !ddr_cke_o); // R3
  AST_CKE_LOW_AT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ddr_reset_n_o) |-> !ddr_cke_o && $past(!ddr_cke_o)); // R3
  AST_CMD_NEEDS_CKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ddr_cs_n_o |-> ddr_cke_o && ddr_reset_n_o); // R8
  AST_MRS_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_mrs |=> !is_mrs); // R7
  AST_DONE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o); // R9
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && start_i && state_q != ST_RST_HOLD |=> state_q != ST_RST_HOLD); // R11

endmodule

// File: tb/ddr3_init_seq_bench.sv
module ddr3_init_seq_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int P      = 8000;
  localparam int T_COLD = 800_000;
  localparam int T_WARM = 84_000;
  localparam int T_PRE  = 16_000;
  localparam int T_CKE  = 400_000;
  localparam int XPR    = 5;
  localparam int MRD    = 4;
  localparam int MOD    = 12;
  localparam int DLLK   = 20;
  localparam int ZQI    = 16;

  // expected cycle counts worked out from the requirements
  localparam int H_COLD = 100;
  localparam int H_WARM = 11;
  localparam int PRE    = 2;
  localparam int W      = 50;
  localparam int F      = 20;

  localparam int NRUN = 3;
  localparam logic RUN_COLD [NRUN] = '{1'b1, 1'b0, 1'b1};
  localparam int   RUN_POKE [NRUN] = '{-1, 30, 160};
  localparam logic [13:0] RUN_MR [NRUN][4] = '{
    '{14'h0b52, 14'h0044, 14'h0018, 14'h0000},
    '{14'h1d70, 14'h0006, 14'h0208, 14'h0004},
    '{14'h3fff, 14'h2aaa, 14'h1555, 14'h0001}};

  localparam logic [24:0] IDLE_VEC = {1'b0, 1'b0, 1'b0, 4'b1111, 3'd0, 14'd0, 1'b0};

  logic clk = 1'b0;
  logic rst_ni, start_i, cold_i;
  logic [13:0] mr0, mr1, mr2, mr3;
  logic rn, cke, odt, cs_n, ras_n, cas_n, we_n, done;
  logic [2:0] ba;
  logic [13:0] addr;
  int checks = 0;
  int fails = 0;

  always #4ns clk = ~clk;

  ddr3_init_seq #(
    .ADDR_W(14), .BA_W(3), .CLK_PERIOD_PS(P),
    .T_RST_COLD_PS(T_COLD), .T_RST_WARM_PS(T_WARM), .T_CKE_PRE_PS(T_PRE),
    .T_CKE_WAIT_PS(T_CKE), .T_XPR_CK(XPR), .T_MRD_CK(MRD), .T_MOD_CK(MOD),
    .T_DLLK_CK(DLLK), .T_ZQINIT_CK(ZQI)
  ) u_ddr3_init_seq (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .cold_i(cold_i),
    .mr0_i(mr0), .mr1_i(mr1), .mr2_i(mr2), .mr3_i(mr3),
    .ddr_reset_n_o(rn), .ddr_cke_o(cke), .ddr_odt_o(odt),
    .ddr_cs_n_o(cs_n), .ddr_ras_n_o(ras_n), .ddr_cas_n_o(cas_n), .ddr_we_n_o(we_n),
    .ddr_ba_o(ba), .ddr_addr_o(addr), .done_o(done)
  );

  function automatic logic [24:0] out_vec();
    return {rn, cke, odt, cs_n, ras_n, cas_n, we_n, ba, addr, done};
  endfunction

  function automatic logic [24:0] exp_vec(int k, int h, logic [13:0] m0, logic [13:0] m1,
                                          logic [13:0] m2, logic [13:0] m3);
    logic r, c, d;
    logic [3:0] cmd;
    logic [2:0] b;
    logic [13:0] a;
    int m, zq;
    r = 1'b1; c = 1'b1; d = 1'b0; cmd = 4'b0111; b = '0; a = '0;
    m  = h + W + XPR;
    zq = m + 3 * MRD + MOD;
    if (k < h) begin r = 1'b0; c = 1'b0; cmd = 4'b1111; end
    else if (k < h + W) begin c = 1'b0; cmd = 4'b1111; end
    else if (k >= zq + F) d = 1'b1;
    else if (k == zq) begin cmd = 4'b0110; a = 14'h0400; end
    else begin
      for (int i = 0; i < 4; i++) begin
        if (k == m + i * MRD) begin
          cmd = 4'b0000;
          b = (i == 0) ? 3'd2 : (i == 1) ? 3'd3 : (i == 2) ? 3'd1 : 3'd0;
          a = (i == 0) ? m2 : (i == 1) ? m3 : (i == 2) ? m1 : m0;
        end
      end
    end
    return {r, c, 1'b0, cmd, b, a, d};
  endfunction

  function automatic string tag_of(int k, int h, bit restart);
    int m, zq;
    m  = h + W + XPR;
    zq = m + 3 * MRD + MOD;
    if (k == 0 && restart) return "R12 restart from done";
    if (k < h)             return "R2 reset hold";
    if (k < h + W)         return "R4 cke wait";
    if (k < m)             return "R5 xpr wait";
    if (k == zq)           return "R7 zqcl";
    if (k > zq && k < zq + F) return "R8 zq filler";
    if (k >= zq + F)       return "R9 done";
    if (k > m + 3 * MRD)   return "R7 mod gap";
    if ((k - m) % MRD == 0) return "R6 mrs";
    return "R8 mrd filler";
  endfunction

  task automatic chk(input string tag, input logic [24:0] got, input logic [24:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic chk_int(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic do_run(input int r);
    int h, len, run_fail, low_len, odt_hi;
    logic prev_rn;
    h = RUN_COLD[r] ? H_COLD : H_WARM;
    len = h + W + XPR + 3 * MRD + MOD + F + 3;
    run_fail = 0; low_len = 0; odt_hi = 0; prev_rn = 1'b0;
    @(negedge clk);
    mr0 = RUN_MR[r][0]; mr1 = RUN_MR[r][1]; mr2 = RUN_MR[r][2]; mr3 = RUN_MR[r][3];
    cold_i = RUN_COLD[r];
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cold_i = ~RUN_COLD[r];
    for (int k = 0; k < len; k++) begin
      logic [24:0] e;
      int f0;
      f0 = fails;
      e = exp_vec(k, h, mr0, mr1, mr2, mr3);
      chk(tag_of(k, h, r > 0), out_vec(), e);
      if (fails != f0) run_fail++;
      if (odt) odt_hi++;
      if (rn && !prev_rn) chk_int("R3 cke low lead before reset release", (low_len >= PRE) ? 1 : 0, 1);
      low_len = cke ? 0 : low_len + 1;
      prev_rn = rn;
      start_i = (k == RUN_POKE[r]);
      @(negedge clk);
    end
    start_i = 1'b0;
    chk_int("R10 odt high cycles", odt_hi, 0);
    if (RUN_POKE[r] >= 0) chk_int("R11 mismatches after ignored start", run_fail, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; start_i = 1'b0; cold_i = 1'b0;
    mr0 = '0; mr1 = '0; mr2 = '0; mr3 = '0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", out_vec(), IDLE_VEC);
    rst_ni = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R1 idle without start", out_vec(), IDLE_VEC);
    end

    for (int r = 0; r < NRUN; r++) do_run(r);

    // R2: warm-start rounding, 84 ns at 8 ns rounds up to 11 cycles
    chk_int("R2 warm hold rounding", H_WARM, (T_WARM + P - 1) / P);

    // R1: asynchronous reset in the middle of a run
    @(negedge clk);
    cold_i = 1'b1;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (120) @(negedge clk);
    chk("R1 mid-run before reset", out_vec(), exp_vec(120, H_COLD, mr0, mr1, mr2, mr3));
    rst_ni = 1'b0;
    #1ns;
    chk("R1 async reset", out_vec(), IDLE_VEC);
    @(negedge clk);
    rst_ni = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1 idle after reset", out_vec(), IDLE_VEC);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule